// File: doc/BRIEF.md
# Configurable-Width IQ Sample Packer

This block takes a stream of complex baseband samples, one 16-bit in-phase (I) and one 16-bit quadrature (Q) component per transfer. It reduces each component to a width chosen at run time (16, 8, 4, 2 or 1 bits) and packs the reduced pairs into 32-bit output words. Fewer bits per sample means more pairs per word, so the output bandwidth for a given sample rate drops with the chosen width.

Words are little-endian. By default the oldest pair sits in the least significant bits, so a consumer that pulls fields from the bottom of the word upward sees samples in arrival order. Within every pair the I field occupies the lower bits and the Q field sits directly above it. A reverse setting mirrors the order of pairs inside each word, which suits recording straight to storage. Both sides use valid/ready handshakes. A flush request, or a change of format in the middle of a word, closes the current partial word with zero padding, so no word ever mixes two formats.

Top module: `iq_width_packer`

## Requirements
- R1: After reset, out_valid is low, in_ready is high and no partial word is held. A flush request given before any sample arrives produces no output word.
- R2: Each component is reduced to N bits by keeping its N most significant bits (truncation). The two's-complement sign is kept.
- R3: The cfg_width code selects N: 0 gives 16, 1 gives 8, 2 gives 4, 3 gives 2 and 4 gives 1. With cfg_reverse=0, pair k of a word (k=0 oldest) occupies bits [2Nk +: 2N]. Within that field, I is in the lower N bits and Q in the upper N bits.
- R4: A word is emitted only when it holds exactly 32/(2N) pairs: 1, 2, 4, 8 or 16 pairs for codes 0 to 4.
- R5: With cfg_reverse=1, pair k is placed in slot C-1-k, where C is the pair count from R4 and slot s covers bits [2Ns +: 2N].
- R6: A one-cycle flush pulse given while a partial word is held emits that word, with every unused slot zero, as soon as the output register is free. No sample is accepted until the flush is done.
- R7: A change of cfg_width or cfg_reverse while a partial word is held first emits that partial word in the old format, as in R6. Samples that follow use the new format from a fresh word.
- R8: While out_valid is high and out_ready is low, out_valid stays high, out_data is stable and in_ready is low. No sample or word is lost under backpressure.
- R9: The unused cfg_width codes 5, 6 and 7 behave exactly like code 0 (16-bit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 3 | Component width code (see R3, R9) |
| cfg_reverse | input | 1 | 1 = reverse pair order within a word |
| flush | input | 1 | One-cycle pulse: emit the current partial word |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Packer accepts a pair this cycle |
| in_i | input | 16 | In-phase component, two's complement |
| in_q | input | 16 | Quadrature component, two's complement |
| out_valid | output | 1 | out_data holds a finished word |
| out_ready | input | 1 | Downstream takes the word this cycle |
| out_data | output | 32 | Packed output word |

## Verification
A wrong fill count shows up at the ports as a word emitted one or more pairs early or late. Because the count sets the slot of every later pair, it also shifts every field of that word, and the first mismatched word gives it away. A stale latched format, or a dropped flush request, shows within one word as padding in the wrong place or as a word that mixes widths. A fault in the output register under backpressure shows within the stall itself: out_data changes, or in_ready rises, while out_ready is low. The bench sweeps every width with both orderings and compares each word bit for bit against an arithmetic model.

// File: rtl/iq_pack_pkg.sv
package iq_pack_pkg;

    localparam int SAMPLE_W = 16;
    localparam int WORD_W   = 32;
    localparam int NUM_WID  = 5;
    localparam int BASE_CAP = WORD_W / (2 * SAMPLE_W);
    localparam int MAX_CAP  = BASE_CAP << (NUM_WID - 1);
    localparam int FILL_W   = $clog2(MAX_CAP + 1);
    localparam int SHIFT_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        WID_16 = 3'd0,
        WID_8  = 3'd1,
        WID_4  = 3'd2,
        WID_2  = 3'd3,
        WID_1  = 3'd4
    } wid_e;

    typedef struct packed {
        wid_e wid;
        logic rev;
    } fmt_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] q;
        logic [SAMPLE_W-1:0] i;
    } pair_t;

    function automatic wid_e decode_wid(input logic [2:0] code);
        if (code > 3'd4) return WID_16;
        return wid_e'(code);
    endfunction

    function automatic logic [FILL_W-1:0] pairs_per_word(input wid_e w);
        return FILL_W'(BASE_CAP << int'(w));
    endfunction

    function automatic int pair_bits(input wid_e w);
        return (2 * SAMPLE_W) >> int'(w);
    endfunction

endpackage

// File: rtl/iq_quantizer.sv
module iq_quantizer
    import iq_pack_pkg::*;
(
    input  pair_t             smp,
    input  wid_e              wid,
    output logic [WORD_W-1:0] field
);

    logic [WORD_W-1:0] cand [NUM_WID];

    for (genvar g = 0; g < NUM_WID; g++) begin : g_width
        localparam int N = SAMPLE_W >> g;
        logic [2*N-1:0] packed_pair;
        assign packed_pair = {smp.q[SAMPLE_W-1 -: N], smp.i[SAMPLE_W-1 -: N]};
        assign cand[g]     = WORD_W'(packed_pair);
    end

    always_comb begin
        field = cand[0];
        for (int k = 1; k < NUM_WID; k++) begin
            if (int'(wid) == k) field = cand[k];
        end
    end

endmodule

// File: rtl/iq_slot_placer.sv
module iq_slot_placer
    import iq_pack_pkg::*;
(
    input  logic [WORD_W-1:0] field,
    input  wid_e              wid,
    input  logic [FILL_W-1:0] slot,
    output logic [WORD_W-1:0] placed
);

    logic [SHIFT_W-1:0] shamt;

    always_comb begin
        shamt  = SHIFT_W'(int'(slot) * pair_bits(wid));
        placed = field << shamt;
    end

endmodule

// File: rtl/iq_pack_ctrl.sv
module iq_pack_ctrl
    import iq_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fmt_t              cfg_fmt,
    input  logic              flush,
    input  logic              in_valid,
    input  logic              slot_free,
    output logic              in_ready,
    output logic              accept,
    output logic              word_done,
    output logic              emit_partial,
    output fmt_t              eff_fmt,
    output fmt_t              act_fmt,
    output logic [FILL_W-1:0] slot,
    output logic [FILL_W-1:0] fill
);

    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] cap;
    logic              flush_pend;
    logic              has_part;
    logic              need_flush;
    fmt_t              act_q;

    always_comb begin
        has_part     = (fill_q != '0);
        eff_fmt      = has_part ? act_q : cfg_fmt;
        need_flush   = has_part && (flush || flush_pend || (cfg_fmt != act_q));
        in_ready     = slot_free && !need_flush;
        accept       = in_valid && in_ready;
        cap          = pairs_per_word(eff_fmt.wid);
        word_done    = accept && ((fill_q + FILL_W'(1)) == cap);
        emit_partial = need_flush && slot_free;
        slot         = eff_fmt.rev ? (cap - FILL_W'(1) - fill_q) : fill_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q     <= '0;
            act_q      <= '{wid: WID_16, rev: 1'b0};
            flush_pend <= 1'b0;
        end else begin
            if (emit_partial) begin
                fill_q <= '0;
            end else if (accept) begin
                fill_q <= word_done ? '0 : fill_q + FILL_W'(1);
                act_q  <= eff_fmt;
            end
            flush_pend <= has_part && !emit_partial && (flush_pend || flush);
        end
    end

    assign fill    = fill_q;
    assign act_fmt = act_q;

endmodule

// File: rtl/iq_word_stage.sv
module iq_word_stage
    import iq_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              word_done,
    input  logic              emit_partial,
    input  logic [WORD_W-1:0] placed,
    input  logic              out_ready,
    output logic              slot_free,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] merged;
    logic              ov_q;
    logic [WORD_W-1:0] od_q;

    assign merged    = acc_q | placed;
    assign slot_free = !ov_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ov_q  <= 1'b0;
            od_q  <= '0;
        end else if (emit_partial) begin
            od_q  <= acc_q;
            ov_q  <= 1'b1;
            acc_q <= '0;
        end else if (word_done) begin
            od_q  <= merged;
            ov_q  <= 1'b1;
            acc_q <= '0;
        end else begin
            if (accept) acc_q <= merged;
            if (out_ready) ov_q <= 1'b0;
        end
    end

    assign out_valid = ov_q;
    assign out_data  = od_q;

endmodule

// File: rtl/iq_width_packer.sv
module iq_width_packer
    import iq_pack_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          cfg_width,
    input  logic                cfg_reverse,
    input  logic                flush,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_data
);

    fmt_t              cfg_fmt;
    fmt_t              eff_fmt;
    fmt_t              act_fmt;
    pair_t             smp;
    logic              slot_free;
    logic              accept;
    logic              word_done;
    logic              emit_partial;
    logic [FILL_W-1:0] slot;
    logic [FILL_W-1:0] fill_cnt;
    logic [WORD_W-1:0] field;
    logic [WORD_W-1:0] placed;

    assign cfg_fmt = '{wid: decode_wid(cfg_width), rev: cfg_reverse};
    assign smp     = '{q: in_q, i: in_i};

    iq_pack_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cfg_fmt      (cfg_fmt),
        .flush        (flush),
        .in_valid     (in_valid),
        .slot_free    (slot_free),
        .in_ready     (in_ready),
        .accept       (accept),
        .word_done    (word_done),
        .emit_partial (emit_partial),
        .eff_fmt      (eff_fmt),
        .act_fmt      (act_fmt),
        .slot         (slot),
        .fill         (fill_cnt)
    );

    iq_quantizer u_quant (
        .smp   (smp),
        .wid   (eff_fmt.wid),
        .field (field)
    );

    iq_slot_placer u_place (
        .field  (field),
        .wid    (eff_fmt.wid),
        .slot   (slot),
        .placed (placed)
    );

    iq_word_stage u_stage (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .word_done    (word_done),
        .emit_partial (emit_partial),
        .placed       (placed),
        .out_ready    (out_ready),
        .slot_free    (slot_free),
        .out_valid    (out_valid),
        .out_data     (out_data)
    );

endmodule

// File: rtl/iq_width_packer_chk.sv
module iq_width_packer_chk
    import iq_pack_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [FILL_W-1:0] fill,
    input fmt_t              act_fmt,
    input fmt_t              cfg_fmt
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && fill == '0));

    assert_hold_word_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_stall_input_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_fill_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (fill != '0) |-> (fill < pairs_per_word(act_fmt.wid)));

    assert_flush_emit_R6: assert property (@(posedge clk) disable iff (rst)
        (flush && fill != '0 && (!out_valid || out_ready)) |=> (out_valid && fill == '0));

    assert_fmt_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        (fill != '0 && cfg_fmt != act_fmt) |-> !in_ready);

endmodule

bind iq_width_packer iq_width_packer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .fill      (fill_cnt),
    .act_fmt   (act_fmt),
    .cfg_fmt   (cfg_fmt)
);

// File: tb/iq_width_packer_bench.sv
`timescale 1ns/1ps
module iq_width_packer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_width = 3'd0;
    logic        cfg_reverse = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rdy_mode = 0;
    bit finished = 0;

    int cur_w = 0;
    bit cur_r = 0;
    logic [15:0] pend_i [16];
    logic [15:0] pend_q [16];
    int pend_n = 0;
    logic [31:0] exp_q [$];
    logic [31:0] got_q [$];

    always #5 clk = ~clk;

    iq_width_packer u_iq_width_packer (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_reverse(cfg_reverse),
        .flush(flush), .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i),
        .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    always @(posedge clk) begin
        cyc++;
        #1;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) got_q.push_back(out_data);
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word(input int w, input bit r, input int n);
        int nb = 16 >> w;
        int cap = 1 << w;
        longint word = 0;
        for (int k = 0; k < n; k++) begin
            int s = r ? (cap - 1 - k) : k;
            longint ti = longint'(pend_i[k]) >> (16 - nb);
            longint tq = longint'(pend_q[k]) >> (16 - nb);
            longint v = (tq << nb) | ti;
            word = word | (v << (s * 2 * nb));
        end
        return word[31:0];
    endfunction

    task automatic model_close();
        if (pend_n > 0) begin
            exp_q.push_back(model_word(cur_w, cur_r, pend_n));
            pend_n = 0;
        end
    endtask

    task automatic set_cfg(input int code, input bit r);
        model_close();
        cur_w = (code > 4) ? 0 : code;
        cur_r = r;
        @(posedge clk); #1;
        cfg_width = 3'(code);
        cfg_reverse = r;
    endtask

    task automatic send(input logic [15:0] i, input logic [15:0] q);
        @(posedge clk); #1;
        in_i = i; in_q = q; in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        pend_i[pend_n] = i;
        pend_q[pend_n] = q;
        pend_n++;
        if (pend_n == (1 << cur_w)) model_close();
    endtask

    task automatic pulse_flush();
        @(posedge clk); #1;
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        model_close();
    endtask

    task automatic compare(input string req);
        int n;
        repeat (40) @(negedge clk);
        check(got_q.size() == exp_q.size(), req, 32'(got_q.size()), 32'(exp_q.size()));
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int k = 0; k < n; k++) check(got_q[k] === exp_q[k], req, got_q[k], exp_q[k]);
        got_q.delete();
        exp_q.delete();
    endtask

    function automatic logic [15:0] gen(input int seed, input int k);
        return 16'((seed * 40503) + (k * 4093) + 16'h8123);
    endfunction

    initial begin
        #(200000 * 10);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'h0);
        check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'h1);

        pulse_flush();
        compare("R1 R6 flush with no partial word");

        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < 5; w++) begin
                rdy_mode = r;
                set_cfg(w, r[0]);
                for (int k = 0; k < 2 * (1 << w); k++)
                    send(gen(w * 7 + r, k), gen(w * 11 + r + 3, k + 5));
                compare(r ? "R5 R2 R4 reversed sweep" : "R3 R2 R4 normal sweep");
            end
        end
        rdy_mode = 0;

        set_cfg(2, 1'b0);
        for (int k = 0; k < 3; k++) send(gen(91, k), gen(92, k));
        pulse_flush();
        compare("R6 partial flush normal order");

        set_cfg(3, 1'b1);
        for (int k = 0; k < 5; k++) send(gen(93, k), gen(94, k));
        pulse_flush();
        compare("R6 partial flush reversed order");

        set_cfg(1, 1'b0);
        send(16'h8001, 16'h7FFE);
        set_cfg(3, 1'b0);
        for (int k = 0; k < 8; k++) send(gen(95, k), gen(96, k));
        compare("R7 width change mid-word");

        set_cfg(2, 1'b0);
        for (int k = 0; k < 2; k++) send(gen(97, k), gen(98, k));
        set_cfg(2, 1'b1);
        for (int k = 0; k < 4; k++) send(gen(99, k), gen(100, k));
        compare("R7 order change mid-word");

        for (int c = 5; c < 8; c++) begin
            set_cfg(c, 1'b0);
            for (int k = 0; k < 3; k++) send(gen(c, k), gen(c + 50, k));
            compare("R9 unused width code");
        end

        set_cfg(1, 1'b0);
        rdy_mode = 2;
        send(16'h1234, 16'hABCD);
        send(16'hFEDC, 16'h0F0F);
        @(negedge clk);
        held = out_data;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(out_valid == 1'b1, "R8 word held valid", 32'(out_valid), 32'h1);
            check(in_ready == 1'b0, "R8 input stalled", 32'(in_ready), 32'h0);
            check(out_data === held, "R8 data stable", out_data, held);
        end
        rdy_mode = 0;
        send(16'h0001, 16'hFFFF);
        send(16'h7FFF, 16'h8000);
        compare("R8 no loss after stall");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule